// File: doc/BRIEF.md
# Three-Wire Configuration Word Loader

This block takes configuration for a dual-channel frequency synthesizer over a three-wire serial link: a data line, a serial clock and a load strobe. The three wires arrive asynchronously. Each one passes through a two-stage synchronizer into the system clock domain, and the block detects edges there. Each rising edge of the serial clock shifts one data bit into a 23-bit word register, most significant bit first. A rising edge of the load strobe copies that word into one of four holding latches.

The two bits shifted in last form an address. One bit picks the channel and the other picks the latch type, reference or feedback. The two latch types read different fields from the same 23 bits. A reference word carries a 14-bit reference divide ratio, a charge-pump current select bit and two test-select bits. A feedback word carries a 7-bit swallow count, an 11-bit main count, a prescaler-modulus select bit, a phase-detector polarity bit and a shared-output select bit.

A divide ratio below 3 is still latched, but it sets a sticky per-channel warning flag that only reset clears. The system clock must run at least four times faster than the serial clock.

Top module: `cfg_serial_loader`

## Requirements
- R1: Each rising edge of `ser_clk` shifts the current `ser_dat` bit into a 23-bit word, first-sent bit most significant. After 23 edges, the bit sent last sits at position 0.
- R2: A rising edge of `ser_le` copies the word into exactly one latch. With no load, every latched output holds its value.
- R3: Word bit 1 selects the latch type (0 = reference, 1 = feedback), and word bit 0 selects the channel (0 or 1). A load changes no latch other than the addressed one.
- R4: In a reference word, bits 3:2 are the test select (bit 3 high), bits 17:4 are the reference ratio (bit 4 LSB), bit 18 is the current select, and bits 22:19 are ignored.
- R5: In a feedback word, bit 2 is the output select, bit 3 is the prescaler select, bit 4 is the phase polarity, bits 11:5 are the swallow count (bit 5 LSB), and bits 22:12 are the main count (bit 12 LSB).
- R6: `cp_hi` high means the higher pump current. `mon_sel` high routes the phase monitor to the shared output, and low routes the lock signal. Both are the latched bits without change.
- R7: A reference ratio below 3 or a main count below 3 is still latched, and it sets `bad_ref` or `bad_fb` for that channel. The flag stays set until reset.
- R8: Each serial clock pulse shifts exactly one bit, however many system cycles the pulse lasts, provided each phase lasts at least two system cycles.
- R9: Reset clears every latch, every flag and the word register. A strobe with no new bits reloads the word as it stands; after reset that word is all zeros, which loads the channel 0 reference latch with ratio 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Load strobe, asynchronous |
| ref_ratio | output | 2x14 | Reference divide ratio per channel |
| cp_hi | output | 2 | Charge-pump high-current select per channel |
| test_sel | output | 2x2 | Test select bits per channel |
| swallow_a | output | 2x7 | Swallow count per channel |
| prog_n | output | 2x11 | Main count per channel |
| pre_sel | output | 2 | Prescaler modulus select per channel |
| pd_pol | output | 2 | Phase-detector polarity per channel |
| mon_sel | output | 2 | Shared-output source select per channel |
| bad_ref | output | 2 | Sticky flag: reference ratio below 3 |
| bad_fb | output | 2 | Sticky flag: main count below 3 |

## Verification
An internal fault here shows up as a wrong field or a wrong latch. A missed or doubled shift moves every field of the next loaded word by one position, so the fault appears at the outputs within a few system cycles of the next strobe. A wrong address decode either leaves the addressed latch stale or corrupts a neighbouring latch, and both are seen because every output of both channels is compared after each load. Flag faults show up when a later legal load fails to keep the flag set, or when a reset fails to clear it.

// File: rtl/cfgsl_pkg.sv
package cfgsl_pkg;
    localparam int WORD_W    = 23;
    localparam int NCH       = 2;
    localparam int REF_W     = 14;
    localparam int A_W       = 7;
    localparam int N_W       = 11;
    localparam int T_W       = 2;
    localparam int MIN_RATIO = 3;

    typedef struct packed {
        logic [T_W-1:0]   tsel;
        logic [REF_W-1:0] ratio;
        logic             cs;
    } ref_cfg_t;

    typedef struct packed {
        logic           lds;
        logic           sw;
        logic           fc;
        logic [A_W-1:0] a;
        logic [N_W-1:0] n;
    } fb_cfg_t;

    function automatic ref_cfg_t unpack_ref(input logic [WORD_W-1:0] w);
        ref_cfg_t r;
        r.tsel  = w[3:2];
        r.ratio = w[4 +: REF_W];
        r.cs    = w[4 + REF_W];
        return r;
    endfunction

    function automatic fb_cfg_t unpack_fb(input logic [WORD_W-1:0] w);
        fb_cfg_t f;
        f.lds = w[2];
        f.sw  = w[3];
        f.fc  = w[4];
        f.a   = w[5 +: A_W];
        f.n   = w[5 + A_W +: N_W];
        return f;
    endfunction
endpackage

// File: rtl/cfgsl_sync.sv
module cfgsl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/cfgsl_shifter.sv
module cfgsl_shifter #(
    parameter int W = 23
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)        word <= '0;
        else if (shift) word <= {word[W-2:0], din};
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(word)); // R1
    AST_BIT_ENTERS: assert property (@(posedge clk) disable iff (rst)
        shift |=> (word[0] == $past(din)) && (word[W-1:1] == $past(word[W-2:0]))); // R1
endmodule

// File: rtl/cfgsl_latch_bank.sv
module cfgsl_latch_bank
    import cfgsl_pkg::*;
#(
    parameter int CH = NCH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [WORD_W-1:0]   word,
    output ref_cfg_t [CH-1:0]   ref_q,
    output fb_cfg_t  [CH-1:0]   fb_q,
    output logic     [CH-1:0]   bad_ref,
    output logic     [CH-1:0]   bad_fb
);
    ref_cfg_t ref_d;
    fb_cfg_t  fb_d;
    logic     is_fb;

    assign ref_d = unpack_ref(word);
    assign fb_d  = unpack_fb(word);
    assign is_fb = word[1];

    for (genvar i = 0; i < CH; i++) begin : g_ch
        logic hit;
        assign hit = load && (word[0] == 1'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ref_q[i]   <= '0;
                fb_q[i]    <= '0;
                bad_ref[i] <= 1'b0;
                bad_fb[i]  <= 1'b0;
            end else if (hit && !is_fb) begin
                ref_q[i] <= ref_d;
                if (ref_d.ratio < REF_W'(MIN_RATIO)) bad_ref[i] <= 1'b1;
            end else if (hit && is_fb) begin
                fb_q[i] <= fb_d;
                if (fb_d.n < N_W'(MIN_RATIO)) bad_fb[i] <= 1'b1;
            end
        end
    end

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ref_q) && $stable(fb_q)); // R2
    AST_FB_KEEPS_REF: assert property (@(posedge clk) disable iff (rst)
        (load && is_fb) |=> $stable(ref_q)); // R3
    AST_REF_KEEPS_FB: assert property (@(posedge clk) disable iff (rst)
        (load && !is_fb) |=> $stable(fb_q)); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((bad_ref & $past(bad_ref)) == $past(bad_ref))
              && ((bad_fb & $past(bad_fb)) == $past(bad_fb))); // R7
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfgsl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ser_clk,
    input  logic                       ser_dat,
    input  logic                       ser_le,
    output logic [NCH-1:0][REF_W-1:0]  ref_ratio,
    output logic [NCH-1:0]             cp_hi,
    output logic [NCH-1:0][T_W-1:0]    test_sel,
    output logic [NCH-1:0][A_W-1:0]    swallow_a,
    output logic [NCH-1:0][N_W-1:0]    prog_n,
    output logic [NCH-1:0]             pre_sel,
    output logic [NCH-1:0]             pd_pol,
    output logic [NCH-1:0]             mon_sel,
    output logic [NCH-1:0]             bad_ref,
    output logic [NCH-1:0]             bad_fb
);
    localparam int NWIRE = 3;

    logic [NWIRE-1:0] raw, synced;
    logic             prev_clk, prev_le;
    logic             sclk_rise, le_rise;
    logic [WORD_W-1:0] word;
    ref_cfg_t [NCH-1:0] ref_q;
    fb_cfg_t  [NCH-1:0] fb_q;

    assign raw = {ser_le, ser_clk, ser_dat};

    for (genvar k = 0; k < NWIRE; k++) begin : g_sync
        cfgsl_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst(rst), .din(raw[k]), .dout(synced[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_clk <= 1'b0;
            prev_le  <= 1'b0;
        end else begin
            prev_clk <= synced[1];
            prev_le  <= synced[2];
        end
    end

    assign sclk_rise = synced[1] & ~prev_clk;
    assign le_rise   = synced[2] & ~prev_le;

    cfgsl_shifter #(.W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .shift(sclk_rise), .din(synced[0]), .word(word)
    );

    cfgsl_latch_bank #(.CH(NCH)) u_bank (
        .clk(clk), .rst(rst), .load(le_rise), .word(word),
        .ref_q(ref_q), .fb_q(fb_q), .bad_ref(bad_ref), .bad_fb(bad_fb)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_out
        assign ref_ratio[i] = ref_q[i].ratio;
        assign cp_hi[i]     = ref_q[i].cs;
        assign test_sel[i]  = ref_q[i].tsel;
        assign swallow_a[i] = fb_q[i].a;
        assign prog_n[i]    = fb_q[i].n;
        assign pre_sel[i]   = fb_q[i].sw;
        assign pd_pol[i]    = fb_q[i].fc;
        assign mon_sel[i]   = fb_q[i].lds;
    end

    AST_SCLK_PULSE: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |=> !sclk_rise); // R8
    AST_LE_PULSE: assert property (@(posedge clk) disable iff (rst)
        le_rise |=> !le_rise); // R2
endmodule

// File: tb/sim_cfg_serial_loader.sv
module sim_cfg_serial_loader;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic [1:0][13:0] ref_ratio;
    logic [1:0] cp_hi, pre_sel, pd_pol, mon_sel, bad_ref, bad_fb;
    logic [1:0][1:0]  test_sel;
    logic [1:0][6:0]  swallow_a;
    logic [1:0][10:0] prog_n;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfg_serial_loader u0 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
        .ref_ratio(ref_ratio), .cp_hi(cp_hi), .test_sel(test_sel),
        .swallow_a(swallow_a), .prog_n(prog_n), .pre_sel(pre_sel),
        .pd_pol(pd_pol), .mon_sel(mon_sel), .bad_ref(bad_ref), .bad_fb(bad_fb)
    );

    typedef struct packed {
        logic        ch;
        logic        fb;
        logic [1:0]  t;
        logic [13:0] r;
        logic        cs;
        logic        lds;
        logic        sw;
        logic        fc;
        logic [6:0]  a;
        logic [10:0] n;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 2'd1, 14'd100,   1'b1, 1'b0, 1'b0, 1'b0, 7'd0,   11'd0},
        '{1'b1, 1'b0, 2'd2, 14'd16383, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0,   11'd0},
        '{1'b0, 1'b1, 2'd0, 14'd0,     1'b0, 1'b1, 1'b0, 1'b1, 7'd127, 11'd2047},
        '{1'b1, 1'b1, 2'd0, 14'd0,     1'b0, 1'b0, 1'b1, 1'b0, 7'd5,   11'd3},
        '{1'b0, 1'b0, 2'd3, 14'd3,     1'b0, 1'b0, 1'b0, 1'b0, 7'd0,   11'd0},
        '{1'b1, 1'b1, 2'd0, 14'd0,     1'b0, 1'b1, 1'b1, 1'b1, 7'd0,   11'd1234},
        '{1'b0, 1'b0, 2'd0, 14'd2,     1'b1, 1'b0, 1'b0, 1'b0, 7'd0,   11'd0},
        '{1'b1, 1'b1, 2'd0, 14'd0,     1'b0, 1'b0, 1'b0, 1'b1, 7'd1,   11'd1},
        '{1'b0, 1'b0, 2'd2, 14'd500,   1'b1, 1'b0, 1'b0, 1'b0, 7'd0,   11'd0}
    };

    // expected model, per channel
    logic [13:0] e_r [2];
    logic [1:0]  e_t [2];
    logic [6:0]  e_a [2];
    logic [10:0] e_n [2];
    logic        e_cs [2], e_lds [2], e_sw [2], e_fc [2], e_br [2], e_bf [2];

    function automatic logic [22:0] mk_word(input vec_t v);
        logic [22:0] w = '0;
        w[0] = v.ch;
        w[1] = v.fb;
        if (!v.fb) begin
            w[3:2]   = v.t;
            w[17:4]  = v.r;
            w[18]    = v.cs;
            w[22:19] = 4'b1011; // ignored bits, R4
        end else begin
            w[2]     = v.lds;
            w[3]     = v.sw;
            w[4]     = v.fc;
            w[11:5]  = v.a;
            w[22:12] = v.n;
        end
        return w;
    endfunction

    task automatic check(input int got, input int exp, input string what);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            e_r[c] = '0; e_t[c] = '0; e_a[c] = '0; e_n[c] = '0;
            e_cs[c] = 0; e_lds[c] = 0; e_sw[c] = 0; e_fc[c] = 0;
            e_br[c] = 0; e_bf[c] = 0;
        end
    endtask

    task automatic model_load(input vec_t v);
        if (!v.fb) begin
            e_r[v.ch] = v.r; e_t[v.ch] = v.t; e_cs[v.ch] = v.cs;
            if (v.r < 3) e_br[v.ch] = 1'b1;
        end else begin
            e_lds[v.ch] = v.lds; e_sw[v.ch] = v.sw; e_fc[v.ch] = v.fc;
            e_a[v.ch] = v.a; e_n[v.ch] = v.n;
            if (v.n < 3) e_bf[v.ch] = 1'b1;
        end
    endtask

    task automatic check_all(input string ctx);
        for (int c = 0; c < 2; c++) begin
            check(ref_ratio[c], e_r[c],   $sformatf("R4 %s ch%0d ref_ratio", ctx, c));
            check(test_sel[c],  e_t[c],   $sformatf("R4 %s ch%0d test_sel", ctx, c));
            check(cp_hi[c],     e_cs[c],  $sformatf("R6 %s ch%0d cp_hi", ctx, c));
            check(swallow_a[c], e_a[c],   $sformatf("R5 %s ch%0d swallow_a", ctx, c));
            check(prog_n[c],    e_n[c],   $sformatf("R5 %s ch%0d prog_n", ctx, c));
            check(pre_sel[c],   e_sw[c],  $sformatf("R5 %s ch%0d pre_sel", ctx, c));
            check(pd_pol[c],    e_fc[c],  $sformatf("R5 %s ch%0d pd_pol", ctx, c));
            check(mon_sel[c],   e_lds[c], $sformatf("R6 %s ch%0d mon_sel", ctx, c));
            check(bad_ref[c],   e_br[c],  $sformatf("R7 %s ch%0d bad_ref", ctx, c));
            check(bad_fb[c],    e_bf[c],  $sformatf("R7 %s ch%0d bad_fb", ctx, c));
        end
    endtask

    task automatic shift_word(input logic [22:0] w, input int hi_len);
        for (int i = 22; i >= 0; i--) begin
            @(negedge clk) ser_dat = w[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (hi_len) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic pulse_le();
        repeat (3) @(negedge clk);
        ser_le = 1'b1;
        repeat (4) @(negedge clk);
        ser_le = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        model_reset();
        do_reset();
        check_all("R9 reset");

        // table walk: R1 shift order, R2/R3 addressed latch only
        for (int v = 0; v < NV; v++) begin
            shift_word(mk_word(VEC[v]), (v == 4) ? 25 : 3); // v4: long high phase, R8
            pulse_le();
            model_load(VEC[v]);
            check_all($sformatf("R1 R2 R3 vec%0d", v));
        end

        // R9: strobe with no new bits reloads the same word
        pulse_le();
        check_all("R9 reload");

        // R9: after reset the word is zero; a bare strobe loads ch0 reference with 0
        do_reset();
        check_all("R9 reset2");
        pulse_le();
        e_br[0] = 1'b1;
        check_all("R9 zero-word R7");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule